// File: doc/BRIEF.md
# SPI Register Access Slave

This block is an SPI slave that lets an external host read and write a bank of 64 byte-wide registers. The host lowers the active-low select line and clocks bytes most significant bit first. The first byte of every transaction is a command byte. Its top bit picks the direction and the six bits below it pick a register. The block turns the serial traffic into single-cycle read and write strobes on a synchronous register-file port in the system clock domain.

The two directions use different burst shapes. A write burst sends one command byte and then any number of data bytes, and every data byte lands in the same register. A read burst treats every byte as a new command byte. MISO returns the data for the address sent one byte earlier, so the host ends a read burst with a 00h byte that clocks out the last value. The SCK, MOSI and select inputs are brought into the system clock through two-stage synchronisers, and edges are detected in that domain. For this reason the system clock must run at least four times faster than SCK.

The register file answers a read strobe with data one system clock later. MISO changes only on falling SCK edges. It is valid no later than three system clocks after each falling edge, and the host samples it at the end of the SCK high phase.

Top module: `spi_regbank_slave`

## Requirements
- R1: MOSI is sampled on rising SCK edges, MSB first. In a command byte, bit 7 is the direction (1 read, 0 write) and bits 6..1 are the register address. Bit 0 is ignored, so a command byte with bit 0 set reaches the same register.
- R2: In a write burst, each data byte after the command byte produces exactly one write strobe carrying that byte. Every strobe in the burst uses the address from the command byte.
- R3: In a read burst, every MOSI byte produces one read strobe for the address in its bits 6..1, the trailing 00h byte included. MISO byte n+1 carries the register value for the address of byte n, MSB first, and changes only on falling SCK edges.
- R4: A write burst produces no read strobes.
- R5: Raising the select line at any point discards a partial byte and returns the block to the command phase. An aborted partial byte produces no strobe, and the next transaction decodes normally.
- R6: A write strobe and a read strobe never occur in the same cycle, and each strobe lasts exactly one system clock.
- R7: After reset, MISO is 0, both strobes are low and the register address output is 0.
- R8: SCK and MOSI activity while the select line is high produces no strobes and does not disturb the next transaction.
- R9: Read data is ready for MISO even when the falling SCK edge that must present its MSB falls in the same cycle that the data returns from the register file. This happens when SCK runs at the minimum ratio of four system clocks per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| nss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the host |
| reg_addr | output | 6 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Register-file read data, valid one cycle after reg_re |
| reg_re | output | 1 | Single-cycle read strobe |

## Verification
The two functions that can fall in the same cycle are the arrival of read data from the register file and the detection of the falling SCK edge that must put that data's MSB on MISO. The bench forces this collision by running a multi-address read burst with SCK high for two system clocks and low for two. At that rate the data return lands exactly on the detected falling edge. The bench then compares every returned MISO byte with the value the host expects for the previous address. A wrong MSB, or a byte shifted by one bit, shows which of the two actions lost.

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              nss_n,
  output logic              miso,
  output logic [BYTE_W-3:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              reg_re
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  typedef enum logic [1:0] {PH_CMD, PH_RD, PH_WR} phase_t;

  logic [SYNC_STAGES-1:0] sck_q, mosi_q, nss_q;
  logic                   sck_d;
  logic                   sck_s, mosi_s, nss_s;
  logic                   rise, fall, byte_done;
  logic [CNT_W-1:0]       bit_cnt;
  logic [BYTE_W-2:0]      rx_sh;
  logic [BYTE_W-1:0]      full_byte;
  logic [BYTE_W-1:0]      tx_sh;
  logic                   re_q;
  phase_t                 phase;

  assign sck_s     = sck_q[SYNC_STAGES-1];
  assign mosi_s    = mosi_q[SYNC_STAGES-1];
  assign nss_s     = nss_q[SYNC_STAGES-1];
  assign rise      = !nss_s && sck_s && !sck_d;
  assign fall      = !nss_s && !sck_s && sck_d;
  assign full_byte = {rx_sh, mosi_s};
  assign byte_done = rise && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      nss_q  <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[SYNC_STAGES-2:0], sck};
      mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
      nss_q  <= {nss_q[SYNC_STAGES-2:0], nss_n};
      sck_d  <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      phase     <= PH_CMD;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (nss_s) begin
        bit_cnt <= '0;
        phase   <= PH_CMD;
      end else if (rise) begin
        rx_sh   <= full_byte[BYTE_W-2:0];
        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              reg_addr <= full_byte[BYTE_W-2:1];
              if (full_byte[BYTE_W-1]) begin
                reg_re <= 1'b1;
                phase  <= PH_RD;
              end else begin
                phase  <= PH_WR;
              end
            end
            PH_RD: begin
              reg_addr <= full_byte[BYTE_W-2:1];
              reg_re   <= 1'b1;
            end
            PH_WR: begin
              reg_wdata <= full_byte;
              reg_we    <= 1'b1;
            end
            default: phase <= PH_CMD;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) re_q <= 1'b0;
    else        re_q <= reg_re;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      miso  <= 1'b0;
    end else if (nss_s) begin
      tx_sh <= '0;
      miso  <= 1'b0;
    end else if (re_q && fall) begin
      miso  <= reg_rdata[BYTE_W-1];
      tx_sh <= {reg_rdata[BYTE_W-2:0], 1'b0};
    end else if (re_q) begin
      tx_sh <= reg_rdata;
    end else if (fall) begin
      miso  <= tx_sh[BYTE_W-1];
      tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  assert_re_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  assert_miso_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nss_s && !fall) |=> $stable(miso));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nss_s |=> (!reg_we && !reg_re));
  assert_wr_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WR && !nss_s) |=> $stable(reg_addr));
  assert_no_re_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WR && !nss_s) |=> !reg_re);

endmodule

// File: tb/sim_spi_regbank_slave.sv
module sim_spi_regbank_slave;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, mosi = 1'b0, nss_n = 1'b1;
  logic miso, reg_we, reg_re;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, rdata;
  logic [7:0] mem [64];

  int checks = 0, errors = 0, half = 4;
  int we_cnt = 0, re_cnt = 0, ovl = 0;
  logic [5:0] we_addr_log [16];
  logic [7:0] we_data_log [16];
  logic [5:0] re_addr_log [16];

  spi_regbank_slave u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .nss_n(nss_n),
    .miso(miso), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(rdata), .reg_re(reg_re));

  always #2 clk = ~clk;

  initial for (int i = 0; i < 64; i++) mem[i] = 8'(i * 29 + 11);

  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) rdata <= mem[reg_addr];
  end

  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin
      we_addr_log[we_cnt & 15] <= reg_addr;
      we_data_log[we_cnt & 15] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (reg_re) begin
      re_addr_log[re_cnt & 15] <= reg_addr;
      re_cnt <= re_cnt + 1;
    end
    if (reg_we && reg_re) ovl <= ovl + 1;
  end

  // {is_read, address, data expected or written}
  localparam logic [14:0] VEC [9] = '{
    {1'b0, 6'd3,  8'h5A}, {1'b0, 6'd62, 8'hC3}, {1'b0, 6'd0,  8'h01},
    {1'b1, 6'd3,  8'h5A}, {1'b1, 6'd62, 8'hC3}, {1'b1, 6'd0,  8'h01},
    {1'b0, 6'd63, 8'hFF}, {1'b1, 6'd63, 8'hFF}, {1'b1, 6'd17, 8'hF8}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_cyc(half);
      sck = 1'b1;
      wait_cyc(half);
      rx[i] = miso;
      sck = 1'b0;
    end
  endtask

  task automatic begin_txn();
    nss_n = 1'b0;
    wait_cyc(half);
  endtask

  task automatic end_txn();
    wait_cyc(half + 2);
    nss_n = 1'b1;
    wait_cyc(6);
  endtask

  task automatic write1(input logic [7:0] cmd, input logic [7:0] d);
    logic [7:0] rx;
    begin_txn();
    xfer(cmd, rx);
    xfer(d, rx);
    end_txn();
  endtask

  task automatic read1(input logic [5:0] a, output logic [7:0] d);
    logic [7:0] rx;
    begin_txn();
    xfer({1'b1, a, 1'b0}, rx);
    xfer(8'h00, d);
    end_txn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx, r1, r2, r3;
    int w0, r0;
    wait_cyc(3);
    chk(miso == 1'b0, "R7 miso", miso, 0);
    chk(!reg_we && !reg_re, "R7 strobes", {reg_we, reg_re}, 0);
    chk(reg_addr == 6'd0, "R7 addr", reg_addr, 0);
    rst_n = 1'b1;
    wait_cyc(4);

    for (int v = 0; v < 9; v++) begin
      w0 = we_cnt;
      if (!VEC[v][14]) begin
        write1({1'b0, VEC[v][13:8], 1'b0}, VEC[v][7:0]);
        chk(we_cnt == w0 + 1, "R2 count", we_cnt - w0, 1);
        chk(we_addr_log[w0 & 15] == VEC[v][13:8], "R2 addr", we_addr_log[w0 & 15], VEC[v][13:8]);
        chk(we_data_log[w0 & 15] == VEC[v][7:0], "R2 data", we_data_log[w0 & 15], VEC[v][7:0]);
      end else begin
        read1(VEC[v][13:8], rx);
        chk(rx == VEC[v][7:0], "R3 table read", rx, VEC[v][7:0]);
      end
    end

    // R2 R4: three data bytes in one write burst
    w0 = we_cnt; r0 = re_cnt;
    begin_txn();
    xfer({1'b0, 6'd20, 1'b0}, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx);
    end_txn();
    chk(we_cnt == w0 + 3, "R2 burst count", we_cnt - w0, 3);
    for (int k = 0; k < 3; k++) begin
      chk(we_addr_log[(w0 + k) & 15] == 6'd20, "R2 burst addr", we_addr_log[(w0 + k) & 15], 20);
      chk(we_data_log[(w0 + k) & 15] == 8'(8'h11 * (k + 1)), "R2 burst data",
          we_data_log[(w0 + k) & 15], 8'h11 * (k + 1));
    end
    chk(re_cnt == r0, "R4 no read strobe", re_cnt - r0, 0);

    // R3 R9: fast multi-address read burst, data return meets falling edge
    half = 2;
    r0 = re_cnt;
    begin_txn();
    xfer({1'b1, 6'd20, 1'b0}, rx);
    xfer({1'b1, 6'd62, 1'b0}, r1);
    xfer({1'b1, 6'd3, 1'b0}, r2);
    xfer(8'h00, r3);
    end_txn();
    chk(r1 == 8'h33, "R9 fast byte1", r1, 8'h33);
    chk(r2 == 8'hC3, "R9 fast byte2", r2, 8'hC3);
    chk(r3 == 8'h5A, "R9 fast byte3", r3, 8'h5A);
    chk(re_cnt == r0 + 4, "R3 read strobes", re_cnt - r0, 4);
    chk(re_addr_log[(r0 + 3) & 15] == 6'd0, "R3 trailing addr", re_addr_log[(r0 + 3) & 15], 0);
    chk(re_addr_log[(r0 + 1) & 15] == 6'd62, "R3 second addr", re_addr_log[(r0 + 1) & 15], 62);
    half = 4;

    // R1: bit 0 of the command byte set
    write1({1'b0, 6'd9, 1'b1}, 8'hAB);
    read1(6'd9, rx);
    chk(rx == 8'hAB, "R1 bit0 ignored", rx, 8'hAB);

    // R5: abort after four bits
    w0 = we_cnt; r0 = re_cnt;
    begin_txn();
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1; wait_cyc(half); sck = 1'b1; wait_cyc(half); sck = 1'b0;
    end
    end_txn();
    chk(we_cnt == w0 && re_cnt == r0, "R5 no strobe", (we_cnt - w0) + (re_cnt - r0), 0);
    write1({1'b0, 6'd40, 1'b0}, 8'h77);
    chk(we_addr_log[w0 & 15] == 6'd40, "R5 fresh addr", we_addr_log[w0 & 15], 40);
    read1(6'd40, rx);
    chk(rx == 8'h77, "R5 fresh data", rx, 8'h77);

    // R8: clocking while deselected
    w0 = we_cnt; r0 = re_cnt;
    for (int i = 0; i < 20; i++) begin
      mosi = i[0]; wait_cyc(half); sck = 1'b1; wait_cyc(half); sck = 1'b0;
    end
    wait_cyc(6);
    chk(we_cnt == w0 && re_cnt == r0, "R8 idle strobes", (we_cnt - w0) + (re_cnt - r0), 0);
    read1(6'd62, rx);
    chk(rx == 8'hC3, "R8 next txn", rx, 8'hC3);

    chk(ovl == 0, "R6 strobe overlap", ovl, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule